// File: doc/BRIEF.md
# Linear-Count Video Timing Generator

This block produces the raster timing for a display link that streams continuous video. It does not count lines. It runs one counter across the whole frame in pixel clocks, plus a position counter within the line. Every vertical event is an absolute pixel-clock count from the start of the frame: the sync width, the display start and end, and the active start and end. Software folds any per-line skew into those counts. The horizontal skew register moves the horizontal sync pulse along the line.

A register write port programs the timing. The enable register takes effect at once. Every other register is written into a shadow copy, and the shadow loads into the working copy at each frame wrap, or on every cycle while the generator is stopped. A mid-frame write therefore never mixes two timings in one frame.

Inside the display area, an optionally enabled active sub-window marks the pixels that are consumed. Display pixels outside that sub-window are filled with the border color. When an active pixel is requested and the upstream pixel-available input is low, the block switches to the underflow color. With recovery on, the underflow color lasts to the end of the line. With recovery off, it lasts to the end of the frame. A one-cycle frame-start pulse marks each frame counter wrap and can serve as the vertical interrupt source.

Top module: `vtg_linear`

## Requirements
- R1: While the enable register (offset 0x00, bit 0) holds 0, both counters stay at zero, act_o and frame_start_o are 0, sel_o is 0 (blank) and color_o is 0. Each of hsync_o, vsync_o and de_o then sits at its inactive level, which equals its polarity bit. Writing 1 starts the frame counter at 0, and the output for counter value n appears one clock after the clock in which the counter holds n.
- R2: The line period is bits [16+:XW] of offset 0x04, and the line position counter wraps to 0 after that many pixel clocks. Horizontal sync (before polarity) is asserted where the line position x satisfies skew <= x < skew + width. The width is bits [0+:XW] of 0x04 and the skew is offset 0x30.
- R3: The frame length is offset 0x08 in pixel clocks, and the frame counter f wraps to 0 after that many clocks. Vertical sync (before polarity) is asserted for f below the value at offset 0x0C.
- R4: Data enable (before polarity) is asserted when x lies in [first x, last x] and f lies in [display start, display end]. First x is bits [15:0] of 0x10, last x is bits [31:16] of 0x10, display start is offset 0x14 and display end is offset 0x18, all bounds inclusive. An active pixel with data available gives sel_o = 1 (pixel) and color_o = 0.
- R5: The horizontal sub-window is on when bit 31 of 0x1C is set, with start x in bits [0+:XW] and end x in bits [16+:XW]. The vertical sub-window is on when bit 31 of 0x20 is set, with start f in bits [FW-1:0] of 0x20 and end f at 0x24. act_o is the display area narrowed by each enabled dimension. A dimension whose flag is clear does not narrow it.
- R6: A display pixel outside the active sub-window gives sel_o = 2 (border) with color_o equal to offset 0x28, and act_o = 0.
- R7: An active pixel whose pix_valid is low gives sel_o = 3 (underflow) with color_o equal to the low CW bits of 0x2C. pix_valid is ignored outside the active area.
- R8: With recovery on (bit 31 of 0x2C), every later active pixel of the same line also shows underflow, and the next line returns to normal.
- R9: With recovery off, every later active pixel of the frame shows underflow, and the next frame returns to normal.
- R10: Offset 0x38 bit 0 inverts hsync_o, bit 1 inverts vsync_o and bit 2 inverts de_o.
- R11: A write to a timing register made while running takes effect only from the next frame start.
- R12: frame_start_o is a one-cycle pulse, shown for each clock in which the running frame counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Byte offset of the register written |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Upstream pixel available for the current position |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable over the display area, polarity applied |
| act_o | output | 1 | Active-pixel strobe |
| sel_o | output | 2 | Source select: 0 blank, 1 pixel, 2 border, 3 underflow |
| color_o | output | CW | Fill color for border or underflow, 0 otherwise |
| frame_start_o | output | 1 | One-cycle pulse at frame counter 0 |

## Verification
The bench builds the block with XW = 8, FW = 12 and CW = 24, which is small enough for a 10-clock line and a 60-clock, six-line frame. With frames that short, whole multi-frame runs are compared cycle by cycle against a model. Frame wraps, shadow loads after mid-frame writes, and underflow that persists across lines or frames all fall within a few hundred cycles. The same settings keep the sub-window edges and a one-pixel skew of the sync pulse at positions that are easy to pick out.

// File: rtl/vtg_linear_pkg.sv
package vtg_linear_pkg;

  // Byte offsets of the programmable registers
  localparam logic [5:0] A_ENABLE  = 6'h00;
  localparam logic [5:0] A_HTIME   = 6'h04;
  localparam logic [5:0] A_FLEN    = 6'h08;
  localparam logic [5:0] A_VSW     = 6'h0C;
  localparam logic [5:0] A_HDISP   = 6'h10;
  localparam logic [5:0] A_VDSTART = 6'h14;
  localparam logic [5:0] A_VDEND   = 6'h18;
  localparam logic [5:0] A_HACT    = 6'h1C;
  localparam logic [5:0] A_VASTART = 6'h20;
  localparam logic [5:0] A_VAEND   = 6'h24;
  localparam logic [5:0] A_BORDER  = 6'h28;
  localparam logic [5:0] A_UFLOW   = 6'h2C;
  localparam logic [5:0] A_SKEW    = 6'h30;
  localparam logic [5:0] A_POL     = 6'h38;

  typedef enum logic [1:0] {
    SEL_BLANK  = 2'd0,
    SEL_PIXEL  = 2'd1,
    SEL_BORDER = 2'd2,
    SEL_UFLOW  = 2'd3
  } vtg_sel_e;

endpackage

// File: rtl/vtg_linear_regs.sv
// Register file: immediate enable, shadow copies, and a working copy that
// loads from the shadow whenever load_i is high.
module vtg_linear_regs
  import vtg_linear_pkg::*;
#(
  parameter int XW = 12,
  parameter int FW = 20,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [5:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          load_i,
  output logic          en_o,
  output logic [XW-1:0] hper_o,
  output logic [XW-1:0] hsw_o,
  output logic [FW-1:0] flen_o,
  output logic [FW-1:0] vsw_o,
  output logic [XW-1:0] hds_o,
  output logic [XW-1:0] hde_o,
  output logic [FW-1:0] vds_o,
  output logic [FW-1:0] vde_o,
  output logic          ahen_o,
  output logic [XW-1:0] ahs_o,
  output logic [XW-1:0] ahe_o,
  output logic          aven_o,
  output logic [FW-1:0] avs_o,
  output logic [FW-1:0] ave_o,
  output logic [CW-1:0] border_o,
  output logic [CW-1:0] ufcol_o,
  output logic          ufrec_o,
  output logic [XW-1:0] skew_o,
  output logic [2:0]    pol_o
);

  localparam int BUSW = 7 * XW + 6 * FW + 2 * CW + 6;

  logic [XW-1:0] s_hper, s_hsw, s_hds, s_hde, s_ahs, s_ahe, s_skew;
  logic [FW-1:0] s_flen, s_vsw, s_vds, s_vde, s_avs, s_ave;
  logic          s_ahen, s_aven, s_ufrec;
  logic [CW-1:0] s_border, s_ufcol;
  logic [2:0]    s_pol;
  logic          en_q;

  logic [BUSW-1:0] shadow_bus;
  logic [BUSW-1:0] work_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_addr[1:0], wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      s_hper   <= '0;
      s_hsw    <= '0;
      s_flen   <= '0;
      s_vsw    <= '0;
      s_hds    <= '0;
      s_hde    <= '0;
      s_vds    <= '0;
      s_vde    <= '0;
      s_ahen   <= 1'b0;
      s_ahs    <= '0;
      s_ahe    <= '0;
      s_aven   <= 1'b0;
      s_avs    <= '0;
      s_ave    <= '0;
      s_border <= '0;
      s_ufcol  <= '0;
      s_ufrec  <= 1'b0;
      s_skew   <= '0;
      s_pol    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_ENABLE:  en_q <= wr_data[0];
        A_HTIME: begin
          s_hper <= wr_data[16 +: XW];
          s_hsw  <= wr_data[0 +: XW];
        end
        A_FLEN:    s_flen <= wr_data[FW-1:0];
        A_VSW:     s_vsw  <= wr_data[FW-1:0];
        A_HDISP: begin
          s_hde <= wr_data[16 +: XW];
          s_hds <= wr_data[0 +: XW];
        end
        A_VDSTART: s_vds <= wr_data[FW-1:0];
        A_VDEND:   s_vde <= wr_data[FW-1:0];
        A_HACT: begin
          s_ahen <= wr_data[31];
          s_ahe  <= wr_data[16 +: XW];
          s_ahs  <= wr_data[0 +: XW];
        end
        A_VASTART: begin
          s_aven <= wr_data[31];
          s_avs  <= wr_data[FW-1:0];
        end
        A_VAEND:   s_ave    <= wr_data[FW-1:0];
        A_BORDER:  s_border <= wr_data[CW-1:0];
        A_UFLOW: begin
          s_ufrec <= wr_data[31];
          s_ufcol <= wr_data[CW-1:0];
        end
        A_SKEW:    s_skew <= wr_data[XW-1:0];
        A_POL:     s_pol  <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  assign shadow_bus = {s_hper, s_hsw, s_flen, s_vsw, s_hds, s_hde, s_vds, s_vde,
                       s_ahen, s_ahs, s_ahe, s_aven, s_avs, s_ave,
                       s_border, s_ufcol, s_ufrec, s_skew, s_pol};

  always_ff @(posedge clk) begin
    if (rst)         work_q <= '0;
    else if (load_i) work_q <= shadow_bus;
  end

  assign {hper_o, hsw_o, flen_o, vsw_o, hds_o, hde_o, vds_o, vde_o,
          ahen_o, ahs_o, ahe_o, aven_o, avs_o, ave_o,
          border_o, ufcol_o, ufrec_o, skew_o, pol_o} = work_q;

  assign en_o = en_q;

endmodule

// File: rtl/vtg_linear_count.sv
// Frame-wide pixel counter plus position within the line.
module vtg_linear_count #(
  parameter int XW = 12,
  parameter int FW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [XW-1:0] hper,
  input  logic [FW-1:0] flen,
  output logic [XW-1:0] x_o,
  output logic [FW-1:0] f_o,
  output logic          x_last_o,
  output logic          f_last_o
);

  localparam logic [XW-1:0] X_ONE = XW'(1);
  localparam logic [FW-1:0] F_ONE = FW'(1);

  logic [XW-1:0] x_q;
  logic [FW-1:0] f_q;

  assign x_last_o = (x_q == hper - X_ONE);
  assign f_last_o = (f_q == flen - F_ONE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      x_q <= '0;
      f_q <= '0;
    end else if (f_last_o) begin
      x_q <= '0;
      f_q <= '0;
    end else begin
      f_q <= f_q + F_ONE;
      x_q <= x_last_o ? '0 : x_q + X_ONE;
    end
  end

  assign x_o = x_q;
  assign f_o = f_q;

endmodule

// File: rtl/vtg_linear_pixel.sv
// Window decode, underflow tracking and registered outputs.
module vtg_linear_pixel
  import vtg_linear_pkg::*;
#(
  parameter int XW = 12,
  parameter int FW = 20,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [XW-1:0] x,
  input  logic [FW-1:0] f,
  input  logic          x_last,
  input  logic          f_last,
  input  logic          pix_valid,
  input  logic [XW-1:0] hsw,
  input  logic [FW-1:0] vsw,
  input  logic [XW-1:0] hds,
  input  logic [XW-1:0] hde,
  input  logic [FW-1:0] vds,
  input  logic [FW-1:0] vde,
  input  logic          ahen,
  input  logic [XW-1:0] ahs,
  input  logic [XW-1:0] ahe,
  input  logic          aven,
  input  logic [FW-1:0] avs,
  input  logic [FW-1:0] ave,
  input  logic [CW-1:0] border,
  input  logic [CW-1:0] ufcol,
  input  logic          ufrec,
  input  logic [XW-1:0] skew,
  input  logic [2:0]    pol,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          act_o,
  output logic [1:0]    sel_o,
  output logic [CW-1:0] color_o,
  output logic          frame_start_o
);

  logic [XW:0] hs_end;
  logic        hs_l, vs_l, in_h, in_v, disp, win_h, win_v, act, bord;
  logic        uf_now, uf_show, uf_flag;
  vtg_sel_e    sel_d;
  logic [CW-1:0] color_d;
  logic [2:0]  lvl_q;
  vtg_sel_e    sel_q;
  logic [CW-1:0] color_q;
  logic        act_q, fs_q;

  always_comb begin
    hs_end  = {1'b0, skew} + {1'b0, hsw};
    hs_l    = (x >= skew) && ({1'b0, x} < hs_end);
    vs_l    = (f < vsw);
    in_h    = (x >= hds) && (x <= hde);
    in_v    = (f >= vds) && (f <= vde);
    disp    = in_h && in_v;
    win_h   = !ahen || ((x >= ahs) && (x <= ahe));
    win_v   = !aven || ((f >= avs) && (f <= ave));
    act     = disp && win_h && win_v;
    bord    = disp && !act;
    uf_now  = act && !pix_valid;
    uf_show = act && (uf_now || uf_flag);
    if (uf_show) begin
      sel_d   = SEL_UFLOW;
      color_d = ufcol;
    end else if (act) begin
      sel_d   = SEL_PIXEL;
      color_d = '0;
    end else if (bord) begin
      sel_d   = SEL_BORDER;
      color_d = border;
    end else begin
      sel_d   = SEL_BLANK;
      color_d = '0;
    end
  end

  // Underflow memory: cleared at line end (recovery on) or frame end.
  always_ff @(posedge clk) begin
    if (rst || !en)             uf_flag <= 1'b0;
    else if (f_last)            uf_flag <= 1'b0;
    else if (ufrec && x_last)   uf_flag <= 1'b0;
    else if (uf_now)            uf_flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      act_q   <= 1'b0;
      sel_q   <= SEL_BLANK;
      color_q <= '0;
      fs_q    <= 1'b0;
    end else if (!en) begin
      lvl_q   <= pol;
      act_q   <= 1'b0;
      sel_q   <= SEL_BLANK;
      color_q <= '0;
      fs_q    <= 1'b0;
    end else begin
      lvl_q   <= {disp, vs_l, hs_l} ^ pol;
      act_q   <= act;
      sel_q   <= sel_d;
      color_q <= color_d;
      fs_q    <= (f == '0);
    end
  end

  assign hsync_o       = lvl_q[0];
  assign vsync_o       = lvl_q[1];
  assign de_o          = lvl_q[2];
  assign act_o         = act_q;
  assign sel_o         = sel_q;
  assign color_o       = color_q;
  assign frame_start_o = fs_q;

endmodule

// File: rtl/vtg_linear.sv
// Top: linear-count video timing generator. Requires XW <= 15, FW <= 31.
module vtg_linear #(
  parameter int XW = 12,
  parameter int FW = 20,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [5:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          pix_valid,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          act_o,
  output logic [1:0]    sel_o,
  output logic [CW-1:0] color_o,
  output logic          frame_start_o
);

  logic          en_q, load_w;
  logic [XW-1:0] w_hper, w_hsw, w_hds, w_hde, w_ahs, w_ahe, w_skew;
  logic [FW-1:0] w_flen, w_vsw, w_vds, w_vde, w_avs, w_ave;
  logic          w_ahen, w_aven, w_ufrec;
  logic [CW-1:0] w_border, w_ufcol;
  logic [2:0]    w_pol;
  logic [XW-1:0] x_cnt;
  logic [FW-1:0] f_cnt;
  logic          x_last, f_last;

  // Working copy follows the shadow while stopped and at each frame wrap.
  assign load_w = !en_q || f_last;

  vtg_linear_regs #(.XW(XW), .FW(FW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_i(load_w), .en_o(en_q),
    .hper_o(w_hper), .hsw_o(w_hsw), .flen_o(w_flen), .vsw_o(w_vsw),
    .hds_o(w_hds), .hde_o(w_hde), .vds_o(w_vds), .vde_o(w_vde),
    .ahen_o(w_ahen), .ahs_o(w_ahs), .ahe_o(w_ahe),
    .aven_o(w_aven), .avs_o(w_avs), .ave_o(w_ave),
    .border_o(w_border), .ufcol_o(w_ufcol), .ufrec_o(w_ufrec),
    .skew_o(w_skew), .pol_o(w_pol)
  );

  vtg_linear_count #(.XW(XW), .FW(FW)) u_count (
    .clk(clk), .rst(rst), .en(en_q), .hper(w_hper), .flen(w_flen),
    .x_o(x_cnt), .f_o(f_cnt), .x_last_o(x_last), .f_last_o(f_last)
  );

  vtg_linear_pixel #(.XW(XW), .FW(FW), .CW(CW)) u_pixel (
    .clk(clk), .rst(rst), .en(en_q), .x(x_cnt), .f(f_cnt),
    .x_last(x_last), .f_last(f_last), .pix_valid(pix_valid),
    .hsw(w_hsw), .vsw(w_vsw), .hds(w_hds), .hde(w_hde), .vds(w_vds), .vde(w_vde),
    .ahen(w_ahen), .ahs(w_ahs), .ahe(w_ahe), .aven(w_aven), .avs(w_avs), .ave(w_ave),
    .border(w_border), .ufcol(w_ufcol), .ufrec(w_ufrec), .skew(w_skew), .pol(w_pol),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .act_o(act_o),
    .sel_o(sel_o), .color_o(color_o), .frame_start_o(frame_start_o)
  );

endmodule

// File: rtl/vtg_linear_chk.sv
module vtg_linear_chk
  import vtg_linear_pkg::*;
#(
  parameter int FW = 20,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          en_q,
  input logic          f_last,
  input logic [FW-1:0] f_cnt,
  input logic [2:0]    w_pol,
  input logic [CW-1:0] w_border,
  input logic [CW-1:0] w_ufcol,
  input logic          de_o,
  input logic          act_o,
  input logic [1:0]    sel_o,
  input logic [CW-1:0] color_o,
  input logic          frame_start_o
);

  localparam logic [FW-1:0] F_ONE = FW'(1);

  // R1
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> (!frame_start_o && !act_o && sel_o == SEL_BLANK && color_o == '0));

  // R3
  frame_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && !$past(f_last)) |-> (f_cnt == $past(f_cnt) + F_ONE));

  // R12
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && $past(f_last)) |-> (f_cnt == '0));

  // R12
  fs_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o);

  // R4
  act_in_de_chk: assert property (@(posedge clk) disable iff (rst)
    act_o |-> (de_o != $past(w_pol[2])));

  // R6
  border_color_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o == SEL_BORDER) |-> (color_o == $past(w_border) && !act_o));

  // R7
  uflow_color_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o == SEL_UFLOW) |-> (color_o == $past(w_ufcol) && act_o));

endmodule

bind vtg_linear vtg_linear_chk #(.FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .f_last(f_last), .f_cnt(f_cnt),
  .w_pol(w_pol), .w_border(w_border), .w_ufcol(w_ufcol),
  .de_o(de_o), .act_o(act_o), .sel_o(sel_o), .color_o(color_o),
  .frame_start_o(frame_start_o)
);

// File: tb/vtg_linear_tb.sv
module vtg_linear_tb;
  import vtg_linear_pkg::*;

  localparam int XW = 8;
  localparam int FW = 12;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pix_valid = 1'b1;
  logic hsync_o, vsync_o, de_o, act_o, frame_start_o;
  logic [1:0] sel_o;
  logic [CW-1:0] color_o;

  always #10 clk = ~clk;

  vtg_linear #(.XW(XW), .FW(FW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_valid(pix_valid), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .act_o(act_o), .sel_o(sel_o), .color_o(color_o), .frame_start_o(frame_start_o)
  );

  typedef struct {
    int hper, hsw, flen, vsw, hds, hde, vds, vde;
    bit ahen; int ahs, ahe;
    bit aven; int avs, ave;
    int border, ufcol; bit rec; int skew; bit [2:0] pol;
  } cfg_t;

  typedef struct {
    int due;
    logic [30:0] val;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops each expected item in the cycle it falls due.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic [30:0] got;
      e = q.pop_front();
      got = {hsync_o, vsync_o, de_o, act_o, frame_start_o, sel_o, color_o};
      checks++;
      if (got !== e.val) begin
        fails++;
        $display("FAIL %s cyc=%0d actual=%h expected=%h", e.tag, cyc, got, e.val);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_cfg(input cfg_t c);
    wr(A_HTIME,   32'((c.hper << 16) | c.hsw));
    wr(A_FLEN,    32'(c.flen));
    wr(A_VSW,     32'(c.vsw));
    wr(A_HDISP,   32'((c.hde << 16) | c.hds));
    wr(A_VDSTART, 32'(c.vds));
    wr(A_VDEND,   32'(c.vde));
    wr(A_HACT,    {c.ahen, 15'(c.ahe), 16'(c.ahs)});
    wr(A_VASTART, {c.aven, 31'(c.avs)});
    wr(A_VAEND,   32'(c.ave));
    wr(A_BORDER,  32'(c.border));
    wr(A_UFLOW,   {c.rec, 31'(c.ufcol)});
    wr(A_SKEW,    32'(c.skew));
    wr(A_POL,     {29'd0, c.pol});
  endtask

  task automatic check_idle(input bit [2:0] pol, input string tag);
    logic [30:0] got, expv;
    got  = {hsync_o, vsync_o, de_o, act_o, frame_start_o, sel_o, color_o};
    expv = {pol[0], pol[1], pol[2], 1'b0, 1'b0, 2'd0, 24'd0};
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, expv);
    end
  endtask

  // Driver: enables the block, drives pix_valid, optional mid-run write,
  // and queues the expected output of every counter value.
  task automatic run(input cfg_t c, input int ncyc, input int uf_n, input int uf_len,
                     input int wr_n, input logic [5:0] wa, input logic [31:0] wd,
                     input cfg_t pend, input string tag);
    cfg_t cur;
    int x, f, base;
    bit hp, mflag;
    wr(A_ENABLE, 32'd1);
    cur = c; x = 0; f = 0; hp = 0; mflag = 0; base = cyc;
    for (int n = 0; n < ncyc; n++) begin
      bit pv, hs, vs, disp, act, bord, ufn, ufs;
      logic [1:0] sel;
      logic [23:0] col;
      exp_t e;
      pv = !(n >= uf_n && n < uf_n + uf_len);
      pix_valid = pv;
      hs   = (x >= cur.skew) && (x < cur.skew + cur.hsw);
      vs   = (f < cur.vsw);
      disp = (x >= cur.hds) && (x <= cur.hde) && (f >= cur.vds) && (f <= cur.vde);
      act  = disp && (!cur.ahen || (x >= cur.ahs && x <= cur.ahe))
                  && (!cur.aven || (f >= cur.avs && f <= cur.ave));
      bord = disp && !act;
      ufn  = act && !pv;
      ufs  = act && (ufn || mflag);
      if (ufs)       begin sel = 2'd3; col = 24'(cur.ufcol);  end
      else if (act)  begin sel = 2'd1; col = 24'd0;           end
      else if (bord) begin sel = 2'd2; col = 24'(cur.border); end
      else           begin sel = 2'd0; col = 24'd0;           end
      e.due = base + n + 1;
      e.val = {hs ^ cur.pol[0], vs ^ cur.pol[1], disp ^ cur.pol[2], act, (f == 0), sel, col};
      e.tag = tag;
      q.push_back(e);
      if (n == wr_n) begin
        wr_en = 1'b1; wr_addr = wa; wr_data = wd; hp = 1;
      end else begin
        wr_en = 1'b0;
      end
      if (f == cur.flen - 1) begin
        mflag = 0; f = 0; x = 0;
        if (hp) begin cur = pend; hp = 0; end
      end else begin
        if (cur.rec && x == cur.hper - 1) mflag = 0;
        else if (ufn) mflag = 1;
        f++;
        x = (x == cur.hper - 1) ? 0 : x + 1;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    pix_valid = 1'b1;
    while (q.size() > 0) @(negedge clk);
    wr(A_ENABLE, 32'd0);
    @(negedge clk);
    @(negedge clk);
    check_idle(cur.pol, {"R1 stopped after ", tag});
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cfg_t base, sub, norec, wide;
    base = '{hper:10, hsw:2, flen:60, vsw:10, hds:3, hde:7, vds:20, vde:49,
             ahen:0, ahs:0, ahe:0, aven:0, avs:0, ave:0,
             border:24'h00A0B0, ufcol:24'hF00F00, rec:1, skew:0, pol:3'b000};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_idle(3'b000, "R1 reset");

    load_cfg(base);
    // R2 R3 R4 R12: two plain frames, sub-window flags clear (R5)
    run(base, 120, -1, 0, -1, 6'h00, 32'd0, base, "R2 R3 R4 R5 R12 base");

    sub = base;
    sub.ahen = 1; sub.ahs = 4; sub.ahe = 6;
    sub.aven = 1; sub.avs = 30; sub.ave = 39;
    sub.pol = 3'b111; sub.skew = 1;
    load_cfg(sub);
    // R5 R6 R10 R2 (skew)
    run(sub, 65, -1, 0, -1, 6'h00, 32'd0, sub, "R5 R6 R10 R2 subwindow");

    load_cfg(base);
    // R7 R8: underflow with recovery, rest of line only
    run(base, 60, 23, 1, -1, 6'h00, 32'd0, base, "R7 R8 recovery");

    norec = base;
    norec.rec = 0;
    load_cfg(norec);
    // R7 R9: underflow without recovery, lasts to frame end
    run(norec, 120, 23, 1, -1, 6'h00, 32'd0, norec, "R7 R9 no recovery");
    // R7: pix_valid low outside the active area is ignored
    run(norec, 60, 0, 20, -1, 6'h00, 32'd0, norec, "R7 ignored in blanking");

    load_cfg(base);
    wide = base;
    wide.hsw = 4;
    // R11: mid-frame write takes effect at the next frame
    run(base, 120, -1, 0, 15, A_HTIME, 32'((10 << 16) | 4), wide, "R11 shadow");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule